// File: doc/BRIEF.md
# Receive Link Synchronization Monitor

This block watches the receive side of a parallel packet link after deskew and decides, cycle by cycle, whether the link can be trusted. Each cycle it is told three things: whether a training pattern was recognized, whether the current word is a control word, and, on control words, whether the 4-bit diagonal parity check on that word failed. Payload is withheld from downstream logic until the monitor has first seen training and then a run of consecutive clean parity checks.

Once that run is long enough, the monitor declares the link synchronized, clears its alignment-off flag and lets the incoming data-valid strobe through. While synchronized it counts consecutive parity failures on control words. When that count grows past a programmable limit, the monitor drops the link, raises a sticky error bit and goes back to waiting for training. This is what happens when the far-end transmitter is held in reset. The sticky bit stays set until a write-one-to-clear strobe arrives.

Both thresholds are inputs, so the entry run and the exit tolerance can be set independently. A typical entry setting is 16.

Top module: `rx_link_sync_mon`

## Requirements
- R1: While reset is asserted and on the first cycle after it, in_sync_o is 0, align_off_o is 1, data_valid_o is 0 and err_sticky_o is 0.
- R2: Control words with passing parity that arrive before a training indication (train_i=1) has been seen since reset or since the last loss of sync never advance the monitor toward sync.
- R3: After training is seen, in_sync_o rises on the clock edge that registers the N-th consecutive passing control word, where N is enter_thresh_i (a value of 0 acts as 1).
- R4: A control word with failing parity (dip_err_i=1) received before sync is reached restarts the run of passing words from zero.
- R5: While in sync, the monitor leaves sync on the edge that registers consecutive failing control word number exit_thresh_i+1, and then waits for training again.
- R6: While in sync, a control word with passing parity resets the consecutive-failure count to zero.
- R7: err_sticky_o is set on the edge where sync is lost and then holds until a cycle with err_clr_i=1. A set in the same cycle as a clear wins.
- R8: data_valid_o equals data_valid_i while in sync and is 0 otherwise.
- R9: align_off_o is always the inverse of in_sync_o.
- R10: Cycles with ctrl_i=0 change no count, whatever dip_err_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_i | input | 1 | Training pattern recognized this cycle |
| ctrl_i | input | 1 | Current word is a control word carrying a parity check |
| dip_err_i | input | 1 | Parity check of the control word failed (valid with ctrl_i) |
| data_valid_i | input | 1 | Payload valid from the deskewed stream |
| enter_thresh_i | input | CNT_W | Consecutive passing checks needed to enter sync |
| exit_thresh_i | input | CNT_W | Consecutive failing checks tolerated while in sync |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the sticky error |
| data_valid_o | output | 1 | Gated payload valid |
| in_sync_o | output | 1 | Link synchronized (OK indication) |
| align_off_o | output | 1 | Alignment-off status, 1 when not synchronized |
| err_sticky_o | output | 1 | Sticky loss-of-sync error |

## Verification
The bench sweeps entry thresholds 0 to 5 against exit thresholds 0 to 3. For each pair it sends passing control words with no training before it, a run of passing words that stops one short of the threshold, a single failure partway through qualification, and idle cycles that carry a raised error input. Together these separate a design that counts too early, counts off by one, or fails to restart the run. In sync, runs of exactly the tolerated number of failures split by one passing word show that the failure count resets. One failure more must drop sync on the exact edge. A clear strobe is given on that same edge to check that setting the sticky bit wins over clearing it.

// File: rtl/rx_link_sync_mon.sv
module rx_link_sync_mon #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_i,
  input  logic             ctrl_i,
  input  logic             dip_err_i,
  input  logic             data_valid_i,
  input  logic [CNT_W-1:0] enter_thresh_i,
  input  logic [CNT_W-1:0] exit_thresh_i,
  input  logic             err_clr_i,
  output logic             data_valid_o,
  output logic             in_sync_o,
  output logic             align_off_o,
  output logic             err_sticky_o
);
  typedef enum logic [1:0] {ST_TRAIN = 2'd0, ST_QUAL = 2'd1, ST_SYNC = 2'd2} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] good_q;
  logic [CNT_W-1:0] bad_q;
  logic [CNT_W:0]   good_nx, bad_nx, enter_eff;
  logic             chk_ok, chk_bad, qual_done, drop;

  assign chk_ok    = ctrl_i && !dip_err_i;
  assign chk_bad   = ctrl_i &&  dip_err_i;
  assign good_nx   = {1'b0, good_q} + 1'b1;
  assign bad_nx    = {1'b0, bad_q} + 1'b1;
  assign enter_eff = (enter_thresh_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, enter_thresh_i};
  assign qual_done = (st_q == ST_QUAL) && chk_ok && (good_nx >= enter_eff);
  assign drop      = (st_q == ST_SYNC) && chk_bad && (bad_nx > {1'b0, exit_thresh_i});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_TRAIN;
      good_q <= '0;
      bad_q  <= '0;
    end else begin
      case (st_q)
        ST_TRAIN: begin
          good_q <= '0;
          bad_q  <= '0;
          if (train_i) st_q <= ST_QUAL;
        end
        ST_QUAL: begin
          if (qual_done) begin
            st_q   <= ST_SYNC;
            good_q <= '0;
            bad_q  <= '0;
          end else if (chk_bad) begin
            good_q <= '0;
          end else if (chk_ok) begin
            good_q <= good_nx[CNT_W-1:0];
          end
        end
        ST_SYNC: begin
          if (drop) begin
            st_q  <= ST_TRAIN;
            bad_q <= '0;
          end else if (chk_bad) begin
            bad_q <= bad_nx[CNT_W-1:0];
          end else if (chk_ok) begin
            bad_q <= '0;
          end
        end
        default: st_q <= ST_TRAIN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         err_sticky_o <= 1'b0;
    else if (drop)      err_sticky_o <= 1'b1;
    else if (err_clr_i) err_sticky_o <= 1'b0;
  end

  assign in_sync_o    = (st_q == ST_SYNC);
  assign align_off_o  = !in_sync_o;
  assign data_valid_o = data_valid_i && in_sync_o;
endmodule

module rx_link_sync_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_i,
  input logic dip_err_i,
  input logic data_valid_i,
  input logic err_clr_i,
  input logic data_valid_o,
  input logic in_sync_o,
  input logic align_off_o,
  input logic err_sticky_o
);
  p_align_inverse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_off_o == !in_sync_o);
  p_valid_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> (in_sync_o && data_valid_i));
  p_enter_on_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync_o) |-> $past(ctrl_i && !dip_err_i));
  p_drop_on_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync_o) |-> $past(ctrl_i && dip_err_i));
  p_sticky_with_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky_o) |-> $fell(in_sync_o));
  p_sticky_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_sticky_o) |-> $past(err_clr_i));
endmodule

bind rx_link_sync_mon rx_link_sync_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .dip_err_i(dip_err_i),
  .data_valid_i(data_valid_i), .err_clr_i(err_clr_i),
  .data_valid_o(data_valid_o), .in_sync_o(in_sync_o),
  .align_off_o(align_off_o), .err_sticky_o(err_sticky_o)
);

// File: tb/rx_link_sync_mon_test.sv
module rx_link_sync_mon_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic train_i = 1'b0, ctrl_i = 1'b0, dip_err_i = 1'b0, data_valid_i = 1'b0, err_clr_i = 1'b0;
  logic [CNT_W-1:0] enter_thresh_i = '0, exit_thresh_i = '0;
  logic data_valid_o, in_sync_o, align_off_o, err_sticky_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_link_sync_mon #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .train_i(train_i), .ctrl_i(ctrl_i),
    .dip_err_i(dip_err_i), .data_valid_i(data_valid_i),
    .enter_thresh_i(enter_thresh_i), .exit_thresh_i(exit_thresh_i),
    .err_clr_i(err_clr_i), .data_valid_o(data_valid_o), .in_sync_o(in_sync_o),
    .align_off_o(align_off_o), .err_sticky_o(err_sticky_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (enter=%0d exit=%0d)", req, act, exp,
               enter_thresh_i, exit_thresh_i);
    end
  endtask

  task automatic drive(input logic t, input logic c, input logic e, input logic v, input logic clr);
    @(negedge clk);
    train_i = t; ctrl_i = c; dip_err_i = e; data_valid_i = v; err_clr_i = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic rep(input int n, input logic c, input logic e);
    for (int i = 0; i < n; i++) drive(1'b0, c, e, 1'b0, 1'b0);
  endtask

  initial begin
    for (int en = 0; en <= 5; en++) begin
      for (int ex = 0; ex <= 3; ex++) begin
        int eff;
        eff = (en == 0) ? 1 : en;
        enter_thresh_i = CNT_W'(en);
        exit_thresh_i  = CNT_W'(ex);
        @(negedge clk); rst_n = 1'b0;
        train_i = 1'b0; ctrl_i = 1'b0; dip_err_i = 1'b0; data_valid_i = 1'b1; err_clr_i = 1'b0;
        @(posedge clk); #1;
        chk(in_sync_o, 1'b0, "R1 in_sync in reset");
        chk(align_off_o, 1'b1, "R1 align_off in reset");
        chk(data_valid_o, 1'b0, "R1 data_valid in reset");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(err_sticky_o, 1'b0, "R1 sticky after reset");
        chk(data_valid_o, 1'b0, "R1 data_valid after reset");
        rep(eff + 2, 1'b1, 1'b0);
        chk(in_sync_o, 1'b0, "R2 good words before training");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        if (eff > 1) begin
          rep(eff - 1, 1'b1, 1'b0);
          chk(in_sync_o, 1'b0, "R3 one short of entry");
          rep(1, 1'b1, 1'b1);
          chk(in_sync_o, 1'b0, "R4 failure during qualification");
          rep(eff - 1, 1'b1, 1'b0);
          chk(in_sync_o, 1'b0, "R4 run restarted after failure");
          rep(2, 1'b0, 1'b1);
          chk(in_sync_o, 1'b0, "R10 idle cycles do not count");
        end
        rep(1, 1'b1, 1'b0);
        chk(in_sync_o, 1'b1, "R3 sync on final good word");
        chk(align_off_o, 1'b0, "R9 align_off low in sync");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(data_valid_o, 1'b1, "R8 valid passes in sync");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(data_valid_o, 1'b0, "R8 valid low follows input");
        if (ex > 0) begin
          rep(ex, 1'b1, 1'b1);
          chk(in_sync_o, 1'b1, "R5 tolerated failures");
          rep(1, 1'b1, 1'b0);
          rep(ex, 1'b1, 1'b1);
          chk(in_sync_o, 1'b1, "R6 good word reset failure count");
        end
        rep(3, 1'b0, 1'b1);
        chk(in_sync_o, 1'b1, "R10 idle error input ignored in sync");
        drive(1'b0, 1'b1, 1'b1, 1'b1, (ex == 2) ? 1'b1 : 1'b0);
        chk(in_sync_o, 1'b0, "R5 drop on failure exit+1");
        chk(align_off_o, 1'b1, "R9 align_off high after drop");
        chk(err_sticky_o, 1'b1, "R7 sticky set on drop");
        chk(data_valid_o, 1'b0, "R8 valid blocked after drop");
        rep(eff + 1, 1'b1, 1'b0);
        chk(in_sync_o, 1'b0, "R5 training needed again");
        chk(err_sticky_o, 1'b1, "R7 sticky holds");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(err_sticky_o, 1'b0, "R7 sticky cleared by strobe");
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule